// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programming state of four DMA channels: a 16-bit base address and a 16-bit base count for each channel, plus the current address and a progress count that say how far the channel's block transfer has got. Software reaches the sixteen 8-bit halves of these registers through eight byte-wide ports. One byte-pointer flip-flop is shared by all channels and decides whether an access touches the low byte or the high byte. A control unit can force that pointer back to the low byte at any time. The transfer engine reports the bytes or words it has moved through a progress input, and the block tells it when a channel has reached terminal count.

A word-mode parameter lets the same block serve as a 16-bit controller. In that mode the port index is taken one address bit higher, the current address is the base address scaled by two, and the block length is the base count plus one, scaled by two. Readback does not return the base registers. The address port returns the live address, which is the current address moved by the progress in the channel's direction. The count port returns the remaining count.

The progress input has no ready signal. An update is accepted in every cycle in which it is valid, so the engine never sees back-pressure. Register accesses are single-cycle strobes, and a read's byte appears on `acc_rdata` after the clock edge that samples the strobe.

Top module: `dma_chan_regs`

## Requirements
- R1: The port index is `acc_addr` shifted right by WORD_SHIFT, keeping 4 bits. Index bit 0 selects the address register (0) or the count register (1), and index bits 3:1 select the channel. Address bits below WORD_SHIFT are ignored.
- R2: A single byte pointer, shared by all channels, toggles on every read or write of a channel port. A pointer value of 0 selects the low byte (bits 7:0) and 1 selects the high byte (bits 15:8).
- R3: A write with the pointer at 0 replaces bits 7:0 of the selected base register, and a write with the pointer at 1 replaces bits 15:8. No other register changes.
- R4: A high-byte write to either register of a channel reloads that channel's current address from its base address shifted left by WORD_SHIFT, and clears its progress. A low-byte write does neither.
- R5: Address readback is (current address + progress), or (current address − progress) when `dir_dec` for the channel is 1. It is taken modulo 2^(16+WORD_SHIFT), shifted right by WORD_SHIFT, and returned as the byte the pointer selects.
- R6: Count readback is (base count << WORD_SHIFT) − progress, taken modulo 2^(16+WORD_SHIFT), shifted right by WORD_SHIFT, and returned as the byte the pointer selects.
- R7: With `prog_valid` high, `prog_amt` is added to the progress of channel `prog_ch` alone, and the result saturates at the block length L = (base count + 1) << WORD_SHIFT. `tc[k]` is 1 exactly when channel k's progress equals its L.
- R8: `bptr_clr` leaves the pointer at 0 after the edge, even when an access happens in the same cycle. That access still uses the pointer value it found.
- R9: A port whose channel field is NUM_CH or more changes no register and does not move the pointer. A read of such a port returns 0x00.
- R10: When `acc_wr` and `acc_rd` are both high, only the write takes place. `acc_rdata` keeps its value and the pointer toggles once.
- R11: When a high-byte write and a progress update hit the same channel in the same cycle, the progress of that channel ends at 0.
- R12: Reset clears all base registers, current addresses, progress counts, the pointer and `acc_rdata`. All `tc` bits read 0 after reset.
- R13: With WORD_SHIFT = 1 the address, count and length scale as in R1 and R4–R7. For example, a base address of 0x1234 with progress 3 reads back 0x1235, and a base count of 0x0010 with progress 3 reads back 0x000E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| acc_addr | input | 4+WORD_SHIFT | Register port address |
| acc_wr | input | 1 | Write strobe, one cycle per byte |
| acc_rd | input | 1 | Read strobe, one cycle per byte |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Byte from the last read, valid after the sampling edge |
| bptr_clr | input | 1 | Forces the byte pointer to the low byte |
| dir_dec | input | NUM_CH | Per channel, 1 = address moves downward |
| prog_valid | input | 1 | Progress update present |
| prog_ch | input | clog2(NUM_CH) | Channel being serviced |
| prog_amt | input | AMT_W | Units moved in this update |
| tc | output | NUM_CH | Terminal count per channel |

## Verification
The assertions take for granted that `prog_ch` names an existing channel and that every input is at a known level whenever reset is released. They also assume that the strobes last one cycle per byte access, so each sampled edge counts as exactly one access. The stimulus drives all inputs from tasks just after the falling edge, keeps `prog_ch` below four, and returns every strobe to 0 before the next access. Combined accesses, such as a write together with a read, a clear together with a read, or a high-byte write together with a progress update, are produced on purpose as single cycles.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int REG_W    = 16;
  localparam int IDX_W    = 4;
  localparam int CH_SEL_W = 3;

  typedef struct packed {
    logic                hit;
    logic                is_cnt;
    logic [CH_SEL_W-1:0] ch;
  } port_sel_t;

  function automatic logic [7:0] pick_byte(input logic [REG_W-1:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction
endpackage

// File: rtl/dcr_port_decode.sv
module dcr_port_decode
  import dcr_pkg::*;
#(
  parameter int WORD_SHIFT = 0,
  parameter int NUM_CH     = 4,
  localparam int AW        = IDX_W + WORD_SHIFT
) (
  input  logic [AW-1:0] addr,
  output port_sel_t     sel
);
  logic [IDX_W-1:0] idx;

  assign idx        = addr[AW-1:WORD_SHIFT];
  assign sel.is_cnt = idx[0];
  assign sel.ch     = idx[IDX_W-1:1];
  assign sel.hit    = (32'(idx[IDX_W-1:1]) < NUM_CH);

  generate
    if (WORD_SHIFT > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^addr[WORD_SHIFT-1:0];
    end
  endgenerate
endmodule

// File: rtl/dcr_byte_ptr.sv
module dcr_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= 1'b0;
    else if (clr)  ptr <= 1'b0;
    else if (step) ptr <= ~ptr;
  end
endmodule

// File: rtl/dcr_channel.sv
module dcr_channel
  import dcr_pkg::*;
#(
  parameter int WORD_SHIFT = 0,
  parameter int AMT_W      = 8,
  localparam int CURW      = REG_W + WORD_SHIFT,
  localparam int PW        = REG_W + 1 + WORD_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_cnt,
  input  logic             wr_hi,
  input  logic [7:0]       wr_data,
  input  logic             dir_dec,
  input  logic             prog_en,
  input  logic [AMT_W-1:0] prog_amt,
  output logic [REG_W-1:0] addr_rb,
  output logic [REG_W-1:0] cnt_rb,
  output logic [PW-1:0]    prog_o,
  output logic             tc
);
  logic [REG_W-1:0] base_addr_q, base_cnt_q;
  logic [REG_W-1:0] base_addr_nx, base_cnt_nx;
  logic [CURW-1:0]  cur_q;
  logic [PW-1:0]    prog_q;
  logic [REG_W:0]   len_units;
  logic [PW-1:0]    len;
  logic [PW:0]      sum;
  logic [PW-1:0]    prog_sat;
  logic             reload;
  logic [CURW-1:0]  prog_lo, addr_full, cnt_full;

  // byte merge into the base registers
  always_comb begin
    base_addr_nx = base_addr_q;
    base_cnt_nx  = base_cnt_q;
    if (wr_en) begin
      if (wr_cnt) begin
        if (wr_hi) base_cnt_nx[15:8] = wr_data;
        else       base_cnt_nx[7:0]  = wr_data;
      end else begin
        if (wr_hi) base_addr_nx[15:8] = wr_data;
        else       base_addr_nx[7:0]  = wr_data;
      end
    end
  end

  assign reload    = wr_en & wr_hi;
  assign len_units = {1'b0, base_cnt_q} + {{REG_W{1'b0}}, 1'b1};
  assign len       = PW'(len_units) << WORD_SHIFT;
  assign sum       = {1'b0, prog_q} + (PW+1)'(prog_amt);
  assign prog_sat  = (sum >= {1'b0, len}) ? len : sum[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_q       <= '0;
      prog_q      <= '0;
    end else begin
      base_addr_q <= base_addr_nx;
      base_cnt_q  <= base_cnt_nx;
      if (reload) begin
        cur_q  <= CURW'(base_addr_nx) << WORD_SHIFT;
        prog_q <= '0;
      end else if (prog_en) begin
        prog_q <= prog_sat;
      end
    end
  end

  // live readback derived from progress and direction
  assign prog_lo   = prog_q[CURW-1:0];
  assign addr_full = dir_dec ? (cur_q - prog_lo) : (cur_q + prog_lo);
  assign cnt_full  = (CURW'(base_cnt_q) << WORD_SHIFT) - prog_lo;
  assign addr_rb   = addr_full[CURW-1:WORD_SHIFT];
  assign cnt_rb    = cnt_full[CURW-1:WORD_SHIFT];
  assign prog_o    = prog_q;
  assign tc        = (prog_q == len);

  generate
    if (WORD_SHIFT > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^{addr_full[WORD_SHIFT-1:0], cnt_full[WORD_SHIFT-1:0]};
    end
  endgenerate
endmodule

// File: rtl/dcr_read_mux.sv
module dcr_read_mux
  import dcr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0][REG_W-1:0] addr_rb,
  input  logic [NUM_CH-1:0][REG_W-1:0] cnt_rb,
  input  port_sel_t                    sel,
  input  logic                         hi,
  output logic [7:0]                   byte_o
);
  always_comb begin
    byte_o = 8'h00;
    for (int k = 0; k < NUM_CH; k++) begin
      if (sel.hit && (sel.ch == CH_SEL_W'(k))) begin
        byte_o = pick_byte(sel.is_cnt ? cnt_rb[k] : addr_rb[k], hi);
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dcr_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int WORD_SHIFT = 0,
  parameter int AMT_W      = 8,
  localparam int AW        = IDX_W + WORD_SHIFT,
  localparam int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PW        = REG_W + 1 + WORD_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     acc_addr,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  input  logic              bptr_clr,
  input  logic [NUM_CH-1:0] dir_dec,
  input  logic              prog_valid,
  input  logic [CHW-1:0]    prog_ch,
  input  logic [AMT_W-1:0]  prog_amt,
  output logic [NUM_CH-1:0] tc
);
  port_sel_t                    sel;
  logic                         bptr_q;
  logic                         wr_go, rd_go, step;
  logic [7:0]                   rd_byte;
  logic [NUM_CH-1:0][REG_W-1:0] ch_addr_rb, ch_cnt_rb;
  logic [NUM_CH-1:0][PW-1:0]    prog_q;

  dcr_port_decode #(.WORD_SHIFT(WORD_SHIFT), .NUM_CH(NUM_CH)) u_dec (
    .addr (acc_addr),
    .sel  (sel)
  );

  assign step  = (acc_wr | acc_rd) & sel.hit;
  assign wr_go = acc_wr & sel.hit;
  assign rd_go = acc_rd & ~acc_wr;

  dcr_byte_ptr u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (bptr_clr),
    .step  (step),
    .ptr   (bptr_q)
  );

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      dcr_channel #(.WORD_SHIFT(WORD_SHIFT), .AMT_W(AMT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go && (sel.ch == CH_SEL_W'(k))),
        .wr_cnt   (sel.is_cnt),
        .wr_hi    (bptr_q),
        .wr_data  (acc_wdata),
        .dir_dec  (dir_dec[k]),
        .prog_en  (prog_valid && (prog_ch == CHW'(k))),
        .prog_amt (prog_amt),
        .addr_rb  (ch_addr_rb[k]),
        .cnt_rb   (ch_cnt_rb[k]),
        .prog_o   (prog_q[k]),
        .tc       (tc[k])
      );
    end
  endgenerate

  dcr_read_mux #(.NUM_CH(NUM_CH)) u_mux (
    .addr_rb (ch_addr_rb),
    .cnt_rb  (ch_cnt_rb),
    .sel     (sel),
    .hi      (bptr_q),
    .byte_o  (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_rdata <= 8'h00;
    else if (rd_go) acc_rdata <= rd_byte;
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dcr_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int WORD_SHIFT = 0,
  localparam int AW        = IDX_W + WORD_SHIFT,
  localparam int CHW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int PW        = REG_W + 1 + WORD_SHIFT
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [AW-1:0]             acc_addr,
  input logic                      acc_wr,
  input logic                      acc_rd,
  input logic                      bptr_clr,
  input logic                      prog_valid,
  input logic [CHW-1:0]            prog_ch,
  input logic [7:0]                acc_rdata,
  input logic [NUM_CH-1:0]         tc,
  input logic                      bptr_q,
  input logic [NUM_CH-1:0][PW-1:0] prog_q
);
  logic [IDX_W-1:0] cidx;
  logic             port_ok;
  logic             any_acc;

  assign cidx    = acc_addr[AW-1:WORD_SHIFT];
  assign port_ok = (32'(cidx[IDX_W-1:1]) < NUM_CH);
  assign any_acc = acc_wr | acc_rd;

  // R8
  bptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bptr_clr |=> (bptr_q == 1'b0)) else $error("pointer not cleared");

  // R2
  bptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bptr_clr && any_acc && port_ok) |=> (bptr_q != $past(bptr_q))) else $error("pointer did not toggle");

  // R9
  bptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bptr_clr && !(any_acc && port_ok)) |=> $stable(bptr_q)) else $error("pointer moved without access");

  // R9
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_wr && !port_ok) |=> (acc_rdata == 8'h00)) else $error("bad port read not zero");

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_rd || acc_wr) |=> $stable(acc_rdata)) else $error("read data moved without read");

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_k
      // R7
      prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && !(prog_valid && (prog_ch == CHW'(k)))) |=> $stable(prog_q[k]))
        else $error("progress moved on idle channel");

      // R4
      hi_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && port_ok && bptr_q && (32'(cidx[IDX_W-1:1]) == k)) |=> (prog_q[k] == '0))
        else $error("high write left progress");

      // R7
      tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc[k] && !acc_wr && !(prog_valid && (prog_ch == CHW'(k)))) |=> tc[k])
        else $error("terminal count dropped");
    end
  endgenerate
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .WORD_SHIFT(WORD_SHIFT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_addr   (acc_addr),
  .acc_wr     (acc_wr),
  .acc_rd     (acc_rd),
  .bptr_clr   (bptr_clr),
  .prog_valid (prog_valid),
  .prog_ch    (prog_ch),
  .acc_rdata  (acc_rdata),
  .tc         (tc),
  .bptr_q     (bptr_q),
  .prog_q     (prog_q)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;

  logic [3:0] a_addr = '0;
  logic       a_wr = 1'b0, a_rd = 1'b0, a_clr = 1'b0, a_pv = 1'b0;
  logic [7:0] a_wdata = '0, a_amt = '0;
  logic [3:0] a_dir = '0;
  logic [1:0] a_pch = '0;
  logic [7:0] a_rdata;
  logic [3:0] a_tc;

  logic [4:0] b_addr = '0;
  logic       b_wr = 1'b0, b_rd = 1'b0, b_clr = 1'b0, b_pv = 1'b0;
  logic [7:0] b_wdata = '0, b_amt = '0;
  logic [1:0] b_pch = '0;
  logic [7:0] b_rdata;
  logic [3:0] b_tc;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .acc_addr(a_addr), .acc_wr(a_wr), .acc_rd(a_rd),
    .acc_wdata(a_wdata), .acc_rdata(a_rdata), .bptr_clr(a_clr), .dir_dec(a_dir),
    .prog_valid(a_pv), .prog_ch(a_pch), .prog_amt(a_amt), .tc(a_tc)
  );

  dma_chan_regs #(.WORD_SHIFT(1)) u_dma_chan_regs_w (
    .clk(clk), .rst_n(rst_n), .acc_addr(b_addr), .acc_wr(b_wr), .acc_rd(b_rd),
    .acc_wdata(b_wdata), .acc_rdata(b_rdata), .bptr_clr(b_clr), .dir_dec(4'b0000),
    .prog_valid(b_pv), .prog_ch(b_pch), .prog_amt(b_amt), .tc(b_tc)
  );

  // {op, port, data, expected, requirement}; op 1 write, 2 read, 3 clear
  localparam int NV = 35;
  localparam logic [27:0] VEC [NV] = '{
    28'h1_0_34_00_3, 28'h1_0_12_00_3, 28'h1_1_FF_00_3, 28'h1_1_00_00_3, // R3
    28'h2_0_00_34_5, 28'h2_0_00_12_5, 28'h2_1_00_FF_6, 28'h2_1_00_00_6, // R5 R6
    28'h1_2_CD_00_1, 28'h1_2_AB_00_1, 28'h1_3_03_00_1, 28'h1_3_00_00_1, // R1
    28'h2_2_00_CD_1, 28'h2_2_00_AB_1, 28'h2_3_00_03_1, 28'h2_3_00_00_1,
    28'h1_4_78_00_4, 28'h2_4_00_00_2, 28'h2_4_00_00_4, 28'h1_4_56_00_3, // R2 R4
    28'h2_4_00_78_4, 28'h2_4_00_56_4,
    28'h1_8_99_00_9, 28'h2_8_00_00_9, 28'h2_0_00_34_9,                  // R9
    28'h3_0_00_00_8, 28'h2_1_00_FF_8, 28'h3_0_00_00_8,                  // R8
    28'h2_E_00_00_9, 28'h2_3_00_03_2, 28'h2_3_00_00_2,
    28'h2_6_00_00_C, 28'h2_6_00_00_C, 28'h2_7_00_00_C, 28'h2_7_00_00_C  // R12
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit b, input bit wr, input bit rd, input bit clr,
                     input logic [4:0] addr, input logic [7:0] d);
    if (b) begin
      b_addr = addr; b_wr = wr; b_rd = rd; b_clr = clr; b_wdata = d;
    end else begin
      a_addr = addr[3:0]; a_wr = wr; a_rd = rd; a_clr = clr; a_wdata = d;
    end
    @(negedge clk);
    a_wr = 1'b0; a_rd = 1'b0; a_clr = 1'b0;
    b_wr = 1'b0; b_rd = 1'b0; b_clr = 1'b0;
  endtask

  task automatic prog(input bit b, input logic [1:0] ch, input logic [7:0] amt);
    if (b) begin b_pv = 1'b1; b_pch = ch; b_amt = amt; end
    else   begin a_pv = 1'b1; a_pch = ch; a_amt = amt; end
    @(negedge clk);
    a_pv = 1'b0; b_pv = 1'b0;
  endtask

  task automatic rd(input bit b, input logic [4:0] addr, input logic [7:0] exp, input string tag);
    acc(b, 1'b0, 1'b1, 1'b0, addr, 8'h00);
    check(tag, b ? b_rdata : a_rdata, exp);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R12 rdata in reset", a_rdata, 8'h00);
    check("R12 tc in reset", {4'b0, a_tc}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][27:24])
        4'h1: acc(1'b0, 1'b1, 1'b0, 1'b0, {1'b0, VEC[i][23:20]}, VEC[i][19:12]);
        4'h2: rd(1'b0, {1'b0, VEC[i][23:20]}, VEC[i][11:4],
                 $sformatf("R%0d vector %0d", VEC[i][3:0], i));
        default: acc(1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 8'h00);
      endcase
    end

    // R7 progress and saturation on channel 1 (base 0xABCD, count 3, length 4)
    prog(1'b0, 2'd1, 8'd2);
    check("R7 tc below length", {4'b0, a_tc}, 8'h00);
    rd(1'b0, 5'd2, 8'hCF, "R5 live address low");
    rd(1'b0, 5'd2, 8'hAB, "R5 live address high");
    rd(1'b0, 5'd3, 8'h01, "R6 remaining low");
    rd(1'b0, 5'd3, 8'h00, "R6 remaining high");
    prog(1'b0, 2'd1, 8'd5);
    check("R7 tc at saturation", {4'b0, a_tc}, 8'h02);
    rd(1'b0, 5'd3, 8'hFF, "R6 remaining past end low");
    rd(1'b0, 5'd3, 8'hFF, "R6 remaining past end high");
    rd(1'b0, 5'd2, 8'hD1, "R7 saturated address low");
    rd(1'b0, 5'd2, 8'hAB, "R7 saturated address high");
    rd(1'b0, 5'd1, 8'hFF, "R7 other channel count low");
    rd(1'b0, 5'd1, 8'h00, "R7 other channel count high");

    // R5 decrement on channel 0
    a_dir = 4'b0001;
    prog(1'b0, 2'd0, 8'h10);
    rd(1'b0, 5'd0, 8'h24, "R5 decrement low");
    rd(1'b0, 5'd0, 8'h12, "R5 decrement high");
    rd(1'b0, 5'd1, 8'hEF, "R6 count after decrement");
    rd(1'b0, 5'd1, 8'h00, "R6 count high after decrement");
    check("R7 tc unchanged", {4'b0, a_tc}, 8'h02);

    // R11 high write and progress in one cycle
    acc(1'b0, 1'b1, 1'b0, 1'b0, 5'd3, 8'h03);
    a_pv = 1'b1; a_pch = 2'd1; a_amt = 8'd2;
    acc(1'b0, 1'b1, 1'b0, 1'b0, 5'd3, 8'h00);
    a_pv = 1'b0;
    check("R11 tc after reload", {4'b0, a_tc}, 8'h00);
    rd(1'b0, 5'd3, 8'h03, "R11 count low");
    rd(1'b0, 5'd3, 8'h00, "R11 count high");
    rd(1'b0, 5'd2, 8'hCD, "R11 address low");
    rd(1'b0, 5'd2, 8'hAB, "R11 address high");

    // R10 write and read together
    acc(1'b0, 1'b1, 1'b1, 1'b0, 5'd6, 8'h5A);
    check("R10 rdata held", a_rdata, 8'hAB);
    acc(1'b0, 1'b1, 1'b0, 1'b0, 5'd6, 8'h00);
    rd(1'b0, 5'd6, 8'h5A, "R10 write landed low");
    rd(1'b0, 5'd6, 8'h00, "R10 write landed high");

    // R8 clear together with a read
    acc(1'b0, 1'b0, 1'b1, 1'b1, 5'd0, 8'h00);
    check("R8 read with clear", a_rdata, 8'h24);
    rd(1'b0, 5'd0, 8'h24, "R8 pointer back to low");

    // R13 word mode
    acc(1'b1, 1'b1, 1'b0, 1'b0, 5'd4, 8'h34);
    acc(1'b1, 1'b1, 1'b0, 1'b0, 5'd5, 8'h12);
    acc(1'b1, 1'b1, 1'b0, 1'b0, 5'd6, 8'h10);
    acc(1'b1, 1'b1, 1'b0, 1'b0, 5'd6, 8'h00);
    prog(1'b1, 2'd1, 8'd3);
    rd(1'b1, 5'd4, 8'h35, "R13 word address low");
    rd(1'b1, 5'd4, 8'h12, "R13 word address high");
    rd(1'b1, 5'd7, 8'h0E, "R13 word count low");
    rd(1'b1, 5'd7, 8'h00, "R13 word count high");
    check("R13 word tc clear", {4'b0, b_tc}, 8'h00);
    prog(1'b1, 2'd1, 8'h40);
    check("R13 word tc set", {4'b0, b_tc}, 8'h02);
    rd(1'b1, 5'd6, 8'hFF, "R13 word count past end low");
    rd(1'b1, 5'd6, 8'hFF, "R13 word count past end high");
    rd(1'b1, 5'd4, 8'h45, "R13 word end address low");
    rd(1'b1, 5'd4, 8'h12, "R13 word end address high");

    // R12 reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R12 rdata after reset", a_rdata, 8'h00);
    check("R12 tc after reset", {4'b0, a_tc}, 8'h00);
    check("R12 word tc after reset", {4'b0, b_tc}, 8'h00);
    @(negedge clk);
    rd(1'b0, 5'd2, 8'h00, "R12 address cleared low");
    rd(1'b0, 5'd2, 8'h00, "R12 address cleared high");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule